// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control

This block keeps the state of one downstream port of a USB host root hub. Software reaches it through a single register word. A read returns every status bit and every change flag at once. Writes are commands: a 1 in a bit position performs that position's action, and a 0 does nothing. Hardware event inputs move the port state without software. These events are device attach and detach, over-current, babble, power loss and a controller-wide resume.

Two parameterized interval timers run the port reset and the resume from suspend. When a timer finishes, it enables the port and raises a change flag. Commands that need a device are gated on the connect state. If software tries to enable or suspend an empty port, the port state does not change and a connect-change report is raised instead.

Top module: `rh_port_stat`

## Requirements
- R1: After reset, every bit of `rd_data` reads 0 while `ovc_i` is low.
- R2: A pulse on `attach_i` sets connect status (bit 0) and the connect-change flag (bit 16). A pulse on `detach_i` clears connect, enable (bit 1), suspend (bit 2) and reset (bit 4) status. It also sets bit 16, and it sets the enable-change flag (bit 17) if the port was enabled.
- R3: Writing 1 to bit 1 sets enable status when a device is connected. With no device connected, the write leaves enable at 0 and sets bit 16. Writing 0 to bit 1 has no effect.
- R4: Writing 1 to bit 0 clears enable status without setting bit 17.
- R5: Writing 1 to bit 2 sets suspend status only when a device is connected. Otherwise suspend stays 0 and bit 16 is set.
- R6: Babble, power-off or over-current clears an enabled port and sets bit 17.
- R7: Writing 1 to bit 4 while connected raises reset status (bit 4) for exactly RESET_CYCLES cycles. At the end, bit 4 clears, the reset-change flag (bit 20) is set, enable is set and suspend is cleared. The write is ignored when no device is connected.
- R8: Writing 1 to bit 3 while suspended starts a resume, and suspend stays 1 for exactly RESUME_CYCLES cycles. Then suspend clears, the suspend-change flag (bit 18) is set and enable is set. The write is ignored when the port is not suspended.
- R9: Bit 3 reads `ovc_i` in the same cycle. Any change of `ovc_i` sets the over-current-change flag (bit 19).
- R10: A pulse on `glb_resume_i` clears suspend status and cancels a running resume, so bit 18 is not set afterwards.
- R11: Writing 1 to any change flag position (bits 16 to 20) clears that flag. A hardware set of the same flag in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word, write-one encoding |
| rd_data | output | 32 | Status bits [4:0], change flags [20:16] |
| attach_i | input | 1 | Device attach event pulse |
| detach_i | input | 1 | Device detach event pulse |
| ovc_i | input | 1 | Over-current level |
| babble_i | input | 1 | Bus error (babble) event pulse |
| pwr_off_i | input | 1 | Port power switched off |
| glb_resume_i | input | 1 | Controller entered global resume |

## Verification
The port state is visible on `rd_data` one cycle after the edge that captured a command or event. A wrong internal state therefore shows up on the next read. Examples are an enable or suspend bit on a port with no device, or a missing change flag. Timer faults show up at the cycle-exact end of the reset or resume window. An early or late end moves the fall of bit 4 or bit 2 by one or more cycles, and an end that never comes leaves the change flag unset.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int unsigned WORD_W   = 32;
  // status positions (low field)
  localparam int unsigned B_CONN   = 0;
  localparam int unsigned B_EN     = 1;
  localparam int unsigned B_SUSP   = 2;
  localparam int unsigned B_OVC    = 3;
  localparam int unsigned B_RST    = 4;
  // change flags (upper field), indices within the field
  localparam int unsigned CHG_BASE = 16;
  localparam int unsigned NUM_CHG  = 5;
  localparam int unsigned C_CONN   = 0;
  localparam int unsigned C_EN     = 1;
  localparam int unsigned C_SUSP   = 2;
  localparam int unsigned C_OVC    = 3;
  localparam int unsigned C_RST    = 4;
  localparam logic [WORD_W-1:0] USED_MASK =
    (((WORD_W)'(1) << (B_RST + 1)) - 1) |
    ((((WORD_W)'(1) << NUM_CHG) - 1) << CHG_BASE);
endpackage

// File: rtl/rh_interval_timer.sv
module rh_interval_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_ce;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (abort_i) begin
      busy_d = 1'b0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  assign cnt_ce = abort_i | start_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_ce) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q & (cnt_q == '0);
endmodule

// File: rtl/rh_chg_flags.sv
module rh_chg_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d, ce;
    // hardware set has priority over a software clear
    assign d  = set_i[i] | (q & ~clr_i[i]);
    assign ce = set_i[i] | clr_i[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (ce) q <= d;
    end
    assign flags_o[i] = q;
  end
endmodule

// File: rtl/rh_port_stat.sv
module rh_port_stat
  import rh_port_pkg::*;
#(
  parameter int unsigned RESET_CYCLES  = 50,
  parameter int unsigned RESUME_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              attach_i,
  input  logic              detach_i,
  input  logic              ovc_i,
  input  logic              babble_i,
  input  logic              pwr_off_i,
  input  logic              glb_resume_i
);
  logic conn_q, conn_d, en_q, en_d, susp_q, susp_d, ovc_q;
  logic [NUM_CHG-1:0] chg_set, chg_clr, chg_q;
  logic rst_busy, rst_done, rst_start;
  logic res_busy, res_done, res_start, res_abort;
  logic cmd_clr_en, cmd_set_en, cmd_set_susp, cmd_resume, cmd_set_rst;
  logic hw_kill;
  logic [WORD_W-1:0] unused_wr;

  assign unused_wr = wr_data & ~USED_MASK;

  // command decode (write-one)
  assign cmd_clr_en   = wr_en & wr_data[B_CONN];
  assign cmd_set_en   = wr_en & wr_data[B_EN];
  assign cmd_set_susp = wr_en & wr_data[B_SUSP];
  assign cmd_resume   = wr_en & wr_data[B_OVC];
  assign cmd_set_rst  = wr_en & wr_data[B_RST];
  assign chg_clr      = wr_en ? wr_data[CHG_BASE +: NUM_CHG] : '0;

  assign rst_start = cmd_set_rst & conn_q & ~rst_busy;
  assign res_start = cmd_resume & susp_q & ~res_busy;
  assign res_abort = detach_i | glb_resume_i;
  assign hw_kill   = ovc_i | pwr_off_i | babble_i;

  rh_interval_timer #(.CYCLES(RESET_CYCLES)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(rst_start), .abort_i(detach_i),
    .busy_o(rst_busy), .done_o(rst_done));

  rh_interval_timer #(.CYCLES(RESUME_CYCLES)) u_res_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(res_start), .abort_i(res_abort),
    .busy_o(res_busy), .done_o(res_done));

  // next state: later statements take priority
  always_comb begin
    conn_d  = conn_q;
    en_d    = en_q;
    susp_d  = susp_q;
    chg_set = '0;
    if (cmd_set_en) begin
      if (conn_q) en_d = 1'b1;
      else        chg_set[C_CONN] = 1'b1;
    end
    if (cmd_clr_en) en_d = 1'b0;
    if (cmd_set_susp) begin
      if (conn_q) susp_d = 1'b1;
      else        chg_set[C_CONN] = 1'b1;
    end
    if (res_done) begin
      susp_d          = 1'b0;
      en_d            = 1'b1;
      chg_set[C_SUSP] = 1'b1;
    end
    if (rst_done) begin
      susp_d         = 1'b0;
      en_d           = 1'b1;
      chg_set[C_RST] = 1'b1;
    end
    if (glb_resume_i) susp_d = 1'b0;
    if (hw_kill) begin
      if (en_q) chg_set[C_EN] = 1'b1;
      en_d = 1'b0;
    end
    if (ovc_i != ovc_q) chg_set[C_OVC] = 1'b1;
    if (attach_i) begin
      conn_d          = 1'b1;
      chg_set[C_CONN] = 1'b1;
    end
    if (detach_i) begin
      conn_d          = 1'b0;
      en_d            = 1'b0;
      susp_d          = 1'b0;
      chg_set[C_CONN] = 1'b1;
      if (en_q) chg_set[C_EN] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      ovc_q  <= 1'b0;
    end else begin
      conn_q <= conn_d;
      en_q   <= en_d;
      susp_q <= susp_d;
      ovc_q  <= ovc_i;
    end
  end

  rh_chg_flags #(.N(NUM_CHG)) u_chg (
    .clk(clk), .rst_n(rst_n), .set_i(chg_set), .clr_i(chg_clr),
    .flags_o(chg_q));

  always_comb begin
    rd_data                        = '0;
    rd_data[B_CONN]                = conn_q;
    rd_data[B_EN]                  = en_q;
    rd_data[B_SUSP]                = susp_q;
    rd_data[B_OVC]                 = ovc_i;
    rd_data[B_RST]                 = rst_busy;
    rd_data[CHG_BASE +: NUM_CHG]   = chg_q;
  end
endmodule

// File: rtl/rh_port_stat_chk.sv
module rh_port_stat_chk
  import rh_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] rd_data,
  input logic              ovc_i,
  input logic              detach_i,
  input logic              babble_i
);
  a_r9_ovc_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_OVC] == ovc_i);

  a_r2_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
    detach_i |=> (!rd_data[B_CONN] && !rd_data[B_EN] && !rd_data[B_SUSP]
                  && !rd_data[B_RST] && rd_data[CHG_BASE + C_CONN]));

  a_r6_babble_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (babble_i && rd_data[B_EN]) |=> (!rd_data[B_EN] && rd_data[CHG_BASE + C_EN]));

  a_r3_en_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_EN] |-> rd_data[B_CONN]);

  a_r5_susp_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_SUSP] |-> rd_data[B_CONN]);

  a_r7_rst_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_RST] |-> rd_data[B_CONN]);
endmodule

bind rh_port_stat rh_port_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .ovc_i(ovc_i),
  .detach_i(detach_i), .babble_i(babble_i));

// File: tb/rh_port_stat_tb.sv
`timescale 1ns/1ps
module rh_port_stat_tb;
  localparam int RST_N = 5;
  localparam int RES_N = 4;
  localparam logic [31:0] M_CONN = 32'h1, M_EN = 32'h2, M_SUSP = 32'h4,
                          M_OVC = 32'h8, M_RST = 32'h10;
  localparam logic [31:0] F_CONN = 32'h1_0000, F_EN = 32'h2_0000, F_SUSP = 32'h4_0000,
                          F_OVC = 32'h8_0000, F_RST = 32'h10_0000, F_ALL = 32'h1F_0000;

  logic clk = 1'b0;
  logic rst_n, wr_en, attach_i, detach_i, ovc_i, babble_i, pwr_off_i, glb_resume_i;
  logic [31:0] wr_data, rd_data;
  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  rh_port_stat #(.RESET_CYCLES(RST_N), .RESUME_CYCLES(RES_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .attach_i(attach_i), .detach_i(detach_i), .ovc_i(ovc_i), .babble_i(babble_i),
    .pwr_off_i(pwr_off_i), .glb_resume_i(glb_resume_i));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] mask, input logic [31:0] exp);
    vectors++;
    if ((rd_data & mask) !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, rd_data & mask, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset_state();
    chk("R1", 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_attach();
    attach_i = 1'b1; tick(); attach_i = 1'b0;
    chk("R2 attach", M_CONN | F_CONN, M_CONN | F_CONN);
    wr(F_CONN);
    chk("R11 clear", F_CONN, 32'h0);
  endtask

  task automatic t_enable();
    wr(32'h0);
    chk("R3 zero write", 32'hFFFF_FFFF, M_CONN);
    wr(M_EN);
    chk("R3 set", M_EN, M_EN);
    wr(M_CONN);
    chk("R4 clear", M_CONN | M_EN | F_EN, M_CONN);
  endtask

  task automatic t_resume();
    wr(M_EN); wr(M_SUSP);
    chk("R5 set", M_SUSP, M_SUSP);
    wr(M_OVC);
    for (int i = 0; i < RES_N; i++) begin
      chk("R8 held", M_SUSP | F_SUSP, M_SUSP); tick();
    end
    chk("R8 end", M_SUSP | M_EN | F_SUSP, M_EN | F_SUSP);
    wr(F_SUSP);
    wr(M_OVC);
    repeat (RES_N + 1) tick();
    chk("R8 ignored", M_SUSP | F_SUSP, 32'h0);
  endtask

  task automatic t_port_reset();
    wr(M_SUSP);
    for (int i = 0; i < 1; i++) wr(M_RST);
    for (int i = 1; i < RST_N; i++) begin
      chk("R7 active", M_RST | F_RST, M_RST); tick();
    end
    chk("R7 last", M_RST, M_RST); tick();
    chk("R7 end", M_RST | F_RST | M_EN | M_SUSP, F_RST | M_EN);
    wr(F_RST);
  endtask

  task automatic t_hw_kill();
    babble_i = 1'b1; tick(); babble_i = 1'b0;
    chk("R6 babble", M_EN | F_EN, F_EN);
    wr(F_EN); wr(M_EN);
    pwr_off_i = 1'b1; tick(); pwr_off_i = 1'b0;
    chk("R6 power", M_EN | F_EN, F_EN);
    wr(F_EN); wr(M_EN);
    ovc_i = 1'b1; #1;
    chk("R9 mirror", M_OVC, M_OVC);
    tick();
    chk("R6 ovc", M_EN | F_EN | F_OVC, F_EN | F_OVC);
    wr(F_EN | F_OVC);
    chk("R11 clear ovc", F_OVC, 32'h0);
    wr_en = 1'b1; wr_data = F_OVC; ovc_i = 1'b0; tick(); wr_en = 1'b0; wr_data = '0;
    chk("R11 set wins", F_OVC | M_OVC, F_OVC);
    wr(F_ALL);
  endtask

  task automatic t_glb_resume();
    wr(M_EN); wr(M_SUSP); wr(M_OVC);
    glb_resume_i = 1'b1; tick(); glb_resume_i = 1'b0;
    chk("R10 clear", M_SUSP, 32'h0);
    repeat (RES_N + 1) tick();
    chk("R10 cancel", F_SUSP | M_SUSP, 32'h0);
  endtask

  task automatic t_detach();
    detach_i = 1'b1; tick(); detach_i = 1'b0;
    chk("R2 detach", 32'hFFFF_FFFF, F_CONN | F_EN);
    wr(F_ALL);
    wr(M_EN);
    chk("R3 gated", M_EN | F_CONN, F_CONN);
    wr(F_CONN);
    wr(M_SUSP);
    chk("R5 gated", M_SUSP | F_CONN, F_CONN);
    wr(F_CONN);
    wr(M_RST);
    chk("R7 gated", M_RST, 32'h0);
    repeat (RST_N + 1) tick();
    chk("R7 gated end", 32'hFFFF_FFFF, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; attach_i = 1'b0; detach_i = 1'b0;
    ovc_i = 1'b0; babble_i = 1'b0; pwr_off_i = 1'b0; glb_resume_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset_state();
    t_attach();
    t_enable();
    t_resume();
    t_port_reset();
    t_hw_kill();
    t_glb_resume();
    t_detach();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule